// File: doc/BRIEF.md
# Receive Phase Alignment Sequencer

This block brings up the receive phase alignment of a group of serial transceiver lanes. It runs in the user-clock domain. It watches one PLL lock input per lane and waits until every lane has reported lock without a break for a qualification interval. It then drives a sync request to all lanes, either as one long window or as a train of shorter pulses with low gaps between them. Once the sync request is released, the alignment stays frozen where it landed, and the block fires a PCS reset pulse to every lane on the same cycle.

The qualification interval can be counted in two ways, chosen by a parameter. One counts user-clock cycles. The other counts a one-cycle strobe that marks edges of the reference clock. The reset pulse must cover three cycles of the fast user clock. The block converts this into slow user-clock cycles from the fabric byte width. When the sequence finishes, it raises `done`. If lock is lost before that point, the sequence starts again from qualification. A `restart` input starts a new bring-up at any time.

Top module: `rxpa_seq`

## Requirements
- R1: Each lane lock input passes through two synchronizing flops, and the lanes are combined by AND. While any lane is unlocked, no sync request or reset is driven.
- R2: With user-cycle qualification (QUAL_SEL=0), the sync request rises exactly LOCK_HOLD+3 cycles after the cycle in which the last lane lock input goes high.
- R3: With reference qualification (QUAL_SEL=1), the count advances only on clock edges where both `ref_tick` and the synchronized combined lock are high. The count is valid only from the third edge after lock is applied. The sync request rises one cycle after the edge that counts the REF_HOLD-th tick.
- R4: In window mode (PULSED=0), the sync request stays high for exactly SYNC_LEN cycles, and every bit of `lane_sync` changes on the same edge.
- R5: In pulsed mode (PULSED=1), the sync request is PULSE_CNT pulses, each PULSE_LEN cycles high, separated by exactly GAP_LEN low cycles.
- R6: After the last sync cycle, the PCS reset rises RST_DELAY cycles after sync falls. When RST_DELAY is 0, it rises on the same edge that sync falls.
- R7: The PCS reset is high on all lanes together for ceil(3 / FABRIC_BYTES) cycles. FABRIC_BYTES is 1, 2 or 4, giving 3, 2 or 1 cycles.
- R8: `done` rises on the edge where the reset falls and stays high until restart. While `done` is high, loss of lock has no effect. `busy` is the inverse of `done`.
- R9: If any lane lock input falls during sync, gap, delay or reset, sync and reset are low from the third edge after the fall. Qualification then begins again from zero.
- R10: A `restart` pulse sampled at an edge clears `done` on that edge. The new sequence then times its qualification from the restart cycle, just as it would from a fresh lock.
- R11: After reset, `lane_sync`, `lane_pcs_rst` and `done` are low and `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_lock | input | LANES | Per-lane receive PLL lock, asynchronous |
| ref_tick | input | 1 | One-cycle strobe per reference-clock edge, used when QUAL_SEL=1 |
| restart | input | 1 | Synchronous request to start a new bring-up |
| lane_sync | output | LANES | Phase-alignment sync request, same value on all lanes |
| lane_pcs_rst | output | LANES | PCS reset pulse, same value on all lanes |
| done | output | 1 | Bring-up complete |
| busy | output | 1 | Bring-up not complete |

## Verification
The timing rules fix the cycle at which each output change is due. Sync rises LOCK_HOLD+3 cycles after lock is applied, three edges of which are the two synchronizer flops and the state register. A lock drop is visible three edges after it happens. A restart clears `done` one edge later. Gap, delay and reset follow at fixed offsets of the parameters. Two instances run side by side, one in window mode with user-cycle qualification and one in pulsed mode with reference ticks. Before each stimulus, the driver computes the exact cycle and the full output pattern of every change it expects and queues them. The monitor samples at the falling edge and checks each change it observes against the head of the queue for both cycle and value, so any early, late, missing or extra transition is reported.

// File: rtl/rxpa_pkg.sv
package rxpa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_LOCK  = 3'd1,
    ST_SYNC_ON    = 3'd2,
    ST_SYNC_GAP   = 3'd3,
    ST_SYNC_DELAY = 3'd4,
    ST_RESET      = 3'd5,
    ST_DONE       = 3'd6
  } rxpa_state_e;

  // Three fast-clock cycles expressed in slow user-clock cycles, rounded up.
  function automatic int rxpa_rst_cycles(input int fabric_bytes);
    return (3 + fabric_bytes - 1) / fabric_bytes;
  endfunction

  function automatic int rxpa_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rxpa_lock_sync.sv
module rxpa_lock_sync #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lock_async,
  output logic             lock_all
);

  logic [LANES-1:0] meta_q;
  logic [LANES-1:0] stab_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= lock_async[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign lock_all = &stab_q;

endmodule

// File: rtl/rxpa_lock_qual.sv
module rxpa_lock_qual #(
  parameter int QUAL_SEL  = 0,
  parameter int LOCK_HOLD = 12000,
  parameter int REF_HOLD  = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic lock_all,
  input  logic ref_tick,
  output logic qualified
);

  localparam int HOLD = (QUAL_SEL != 0) ? REF_HOLD : LOCK_HOLD;
  localparam int CW   = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          adv;

  // Variant select: count every cycle, or only reference-clock strobes.
  assign adv = (QUAL_SEL != 0) ? ref_tick : 1'b1;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear || !lock_all) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (adv && (cnt_q != HOLD_C)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign qualified = (cnt_q == HOLD_C);

endmodule

// File: rtl/rxpa_fsm.sv
module rxpa_fsm
  import rxpa_pkg::*;
#(
  parameter int ON_LEN    = 64,
  parameter int NPULSE    = 1,
  parameter int GAP_LEN   = 4,
  parameter int RST_DELAY = 0,
  parameter int RST_CYC   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_all,
  input  logic qualified,
  input  logic restart,
  output logic sync_o,
  output logic rst_o,
  output logic done_o,
  output logic qual_clear
);

  localparam int TMAX = rxpa_max(rxpa_max(ON_LEN, GAP_LEN), rxpa_max(RST_DELAY, RST_CYC));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(NPULSE + 1);
  localparam logic [TW-1:0] ON_LAST  = TW'(ON_LEN - 1);
  localparam logic [TW-1:0] GAP_LAST = TW'(rxpa_max(GAP_LEN, 1) - 1);
  localparam logic [TW-1:0] DLY_LAST = TW'(rxpa_max(RST_DELAY, 1) - 1);
  localparam logic [TW-1:0] RST_LAST = TW'(RST_CYC - 1);
  localparam logic [PW-1:0] P_LAST   = PW'(NPULSE - 1);

  rxpa_state_e   state_q, state_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          tcnt_en;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_en;
  logic          timed;
  logic          sync_q, rst_q, done_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    pcnt_en = 1'b0;
    pcnt_d  = pcnt_q;
    case (state_q)
      ST_IDLE: begin
        if (!restart) state_d = ST_WAIT_LOCK;
      end
      ST_WAIT_LOCK: begin
        pcnt_en = 1'b1;
        pcnt_d  = '0;
        if (qualified && lock_all) state_d = ST_SYNC_ON;
      end
      ST_SYNC_ON: begin
        if (tcnt_q == ON_LAST) begin
          if (pcnt_q == P_LAST) begin
            state_d = (RST_DELAY == 0) ? ST_RESET : ST_SYNC_DELAY;
          end else begin
            state_d = ST_SYNC_GAP;
            pcnt_en = 1'b1;
            pcnt_d  = pcnt_q + PW'(1);
          end
        end
      end
      ST_SYNC_GAP: begin
        if (tcnt_q == GAP_LAST) state_d = ST_SYNC_ON;
      end
      ST_SYNC_DELAY: begin
        if (tcnt_q == DLY_LAST) state_d = ST_RESET;
      end
      ST_RESET: begin
        if (tcnt_q == RST_LAST) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!lock_all && (state_q inside {ST_SYNC_ON, ST_SYNC_GAP, ST_SYNC_DELAY, ST_RESET})) begin
      state_d = ST_WAIT_LOCK;
    end
    if (restart) state_d = ST_IDLE;
  end

  // Interval timer, cleared on every state change
  assign timed = state_q inside {ST_SYNC_ON, ST_SYNC_GAP, ST_SYNC_DELAY, ST_RESET};

  always_comb begin
    tcnt_en = 1'b0;
    tcnt_d  = tcnt_q;
    if (state_d != state_q) begin
      tcnt_en = 1'b1;
      tcnt_d  = '0;
    end else if (timed) begin
      tcnt_en = 1'b1;
      tcnt_d  = tcnt_q + TW'(1);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sync_q  <= 1'b0;
      rst_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sync_q  <= (state_d == ST_SYNC_ON);
      rst_q   <= (state_d == ST_RESET);
      done_q  <= (state_d == ST_DONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else if (tcnt_en) begin
      tcnt_q <= tcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  assign sync_o     = sync_q;
  assign rst_o      = rst_q;
  assign done_o     = done_q;
  assign qual_clear = (state_q == ST_IDLE);

endmodule

// File: rtl/rxpa_seq.sv
module rxpa_seq
  import rxpa_pkg::*;
#(
  parameter int LANES        = 4,
  parameter int QUAL_SEL     = 0,
  parameter int LOCK_HOLD    = 12000,
  parameter int REF_HOLD     = 16384,
  parameter int PULSED       = 0,
  parameter int SYNC_LEN     = 64,
  parameter int PULSE_LEN    = 64,
  parameter int PULSE_CNT    = 2,
  parameter int GAP_LEN      = 4,
  parameter int RST_DELAY    = 0,
  parameter int FABRIC_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_lock,
  input  logic             ref_tick,
  input  logic             restart,
  output logic [LANES-1:0] lane_sync,
  output logic [LANES-1:0] lane_pcs_rst,
  output logic             done,
  output logic             busy
);

  localparam int ON_LEN  = (PULSED != 0) ? PULSE_LEN : SYNC_LEN;
  localparam int NPULSE  = (PULSED != 0) ? PULSE_CNT : 1;
  localparam int RST_CYC = rxpa_rst_cycles(FABRIC_BYTES);

  logic rst_meta_q, rst_n_s;
  logic lock_all, qualified, qual_clear;
  logic sync_w, rst_w, done_w;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  rxpa_lock_sync #(.LANES(LANES)) u_lock_sync (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .lock_async (lane_lock),
    .lock_all   (lock_all)
  );

  rxpa_lock_qual #(
    .QUAL_SEL  (QUAL_SEL),
    .LOCK_HOLD (LOCK_HOLD),
    .REF_HOLD  (REF_HOLD)
  ) u_lock_qual (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clear     (qual_clear),
    .lock_all  (lock_all),
    .ref_tick  (ref_tick),
    .qualified (qualified)
  );

  rxpa_fsm #(
    .ON_LEN    (ON_LEN),
    .NPULSE    (NPULSE),
    .GAP_LEN   (GAP_LEN),
    .RST_DELAY (RST_DELAY),
    .RST_CYC   (RST_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .lock_all   (lock_all),
    .qualified  (qualified),
    .restart    (restart),
    .sync_o     (sync_w),
    .rst_o      (rst_w),
    .done_o     (done_w),
    .qual_clear (qual_clear)
  );

  assign lane_sync    = {LANES{sync_w}};
  assign lane_pcs_rst = {LANES{rst_w}};
  assign done         = done_w;
  assign busy         = ~done_w;

endmodule

// File: rtl/rxpa_seq_chk.sv
module rxpa_seq_chk #(
  parameter int LANES   = 4,
  parameter int ON_LEN  = 64,
  parameter int RST_CYC = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_all,
  input logic             restart,
  input logic [LANES-1:0] lane_sync,
  input logic [LANES-1:0] lane_pcs_rst,
  input logic             done
);

  localparam int RW = $clog2(ON_LEN + 1);
  localparam logic [RW-1:0] ON_C = RW'(ON_LEN);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!lane_sync[0]) begin
      run_q <= '0;
    end else if (run_q != ON_C) begin
      run_q <= run_q + RW'(1);
    end
  end

  // R4 R5: a sync pulse not cut short by lock loss or restart lasts its full length
  assert_sync_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lane_sync[0]) && lock_all && !$past(restart)) |-> (run_q == ON_C));

  // R1: sync only starts after combined lock was present
  assert_sync_needs_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_sync[0]) |-> $past(lock_all));

  // R7: the reset pulse covers its minimum slow-cycle count
  assert_rst_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lane_pcs_rst[0]) && lock_all && !$past(restart)) |-> $past(lane_pcs_rst[0], RST_CYC));

  // R6: sync and reset never overlap
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|lane_sync) && (|lane_pcs_rst)));

  // R9: loss of combined lock clears sync and reset on the following edge
  assert_lock_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_all) |=> (!(|lane_sync) && !(|lane_pcs_rst)));

  // R8: done holds until restart
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done);

  // R10: restart clears done
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !done);

endmodule

bind rxpa_seq rxpa_seq_chk #(
  .LANES   (LANES),
  .ON_LEN  (ON_LEN),
  .RST_CYC (RST_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .lock_all     (lock_all),
  .restart      (restart),
  .lane_sync    (lane_sync),
  .lane_pcs_rst (lane_pcs_rst),
  .done         (done)
);

// File: tb/rxpa_seq_tb.sv
module rxpa_seq_tb;

  localparam int HOLD_A = 50;
  localparam int HOLD_B = 10;

  typedef struct {
    int         cyc;
    logic [4:0] pat;
    string      req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] lock_a;
  logic [1:0] lock_b;
  logic       tick = 1'b0;
  logic       restart_a, restart_b;
  logic [2:0] sync_a, prst_a;
  logic [1:0] sync_b, prst_b;
  logic       done_a, busy_a, done_b, busy_b;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  ev_t exp_a[$];
  ev_t exp_b[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick <= ((cyc + 1) % 4 == 0);

  rxpa_seq #(
    .LANES(3), .QUAL_SEL(0), .LOCK_HOLD(HOLD_A), .REF_HOLD(16), .PULSED(0),
    .SYNC_LEN(64), .PULSE_LEN(8), .PULSE_CNT(2), .GAP_LEN(4), .RST_DELAY(2),
    .FABRIC_BYTES(1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .lane_lock(lock_a), .ref_tick(tick), .restart(restart_a),
    .lane_sync(sync_a), .lane_pcs_rst(prst_a), .done(done_a), .busy(busy_a)
  );

  rxpa_seq #(
    .LANES(2), .QUAL_SEL(1), .LOCK_HOLD(50), .REF_HOLD(HOLD_B), .PULSED(1),
    .SYNC_LEN(64), .PULSE_LEN(8), .PULSE_CNT(3), .GAP_LEN(4), .RST_DELAY(0),
    .FABRIC_BYTES(4)
  ) u_dut_b (
    .clk(clk), .rst_n(rst_n), .lane_lock(lock_b), .ref_tick(tick), .restart(restart_b),
    .lane_sync(sync_b), .lane_pcs_rst(prst_b), .done(done_b), .busy(busy_b)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Cycle of the sync rise when qualification is timed from cycle t0
  function automatic int sync_start(input int t0, input bit ref_mode, input int hold);
    int n = 0;
    int e = t0 + 2;
    while (n < hold) begin
      e++;
      if (!ref_mode || (e % 4 == 0)) n++;
    end
    return e + 1;
  endfunction

  // Pattern: {sync any, sync all, reset any, reset all, done}
  task automatic push_a(input int t0);
    int s = sync_start(t0, 1'b0, HOLD_A);
    exp_a.push_back('{s,           5'b11000, "R2"});
    exp_a.push_back('{s + 64,      5'b00000, "R4"});
    exp_a.push_back('{s + 66,      5'b00110, "R6"});
    exp_a.push_back('{s + 69,      5'b00001, "R7"});
  endtask

  task automatic push_b(input int t0);
    int s = sync_start(t0, 1'b1, HOLD_B);
    exp_b.push_back('{s,      5'b11000, "R3"});
    exp_b.push_back('{s + 8,  5'b00000, "R5"});
    exp_b.push_back('{s + 12, 5'b11000, "R5"});
    exp_b.push_back('{s + 20, 5'b00000, "R5"});
    exp_b.push_back('{s + 24, 5'b11000, "R5"});
    exp_b.push_back('{s + 32, 5'b00110, "R6"});
    exp_b.push_back('{s + 33, 5'b00001, "R7"});
  endtask

  task automatic drain();
    while (exp_a.size() != 0 || exp_b.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitors: every output change is compared with the queue head
  logic [4:0] prev_a, prev_b;

  always @(negedge clk) begin
    logic [4:0] cur;
    ev_t e;
    if (!rst_n) begin
      prev_a = 5'b0;
    end else begin
      cur = {|sync_a, &sync_a, |prst_a, &prst_a, done_a};
      if (cur != prev_a) begin
        checks++;
        if (exp_a.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected change A actual=cyc%0d/%b expected=none", cyc, cur);
        end else begin
          e = exp_a.pop_front();
          if (e.cyc != cyc || e.pat != cur) begin
            errors++;
            $display("FAIL %s A actual=cyc%0d/%b expected=cyc%0d/%b", e.req, cyc, cur, e.cyc, e.pat);
          end
        end
        prev_a = cur;
      end
    end
  end

  always @(negedge clk) begin
    logic [4:0] cur;
    ev_t e;
    if (!rst_n) begin
      prev_b = 5'b0;
    end else begin
      cur = {|sync_b, &sync_b, |prst_b, &prst_b, done_b};
      if (cur != prev_b) begin
        checks++;
        if (exp_b.size() == 0) begin
          errors++;
          $display("FAIL R5 unexpected change B actual=cyc%0d/%b expected=none", cyc, cur);
        end else begin
          e = exp_b.pop_front();
          if (e.cyc != cyc || e.pat != cur) begin
            errors++;
            $display("FAIL %s B actual=cyc%0d/%b expected=cyc%0d/%b", e.req, cyc, cur, e.cyc, e.pat);
          end
        end
        prev_b = cur;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t;
    int s;
    rst_n = 1'b0;
    lock_a = '0;
    lock_b = '0;
    restart_a = 1'b0;
    restart_b = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check(sync_a == 0 && prst_a == 0 && !done_a && busy_a, "R11", "reset A", {sync_a, prst_a, done_a}, 0);
    check(sync_b == 0 && prst_b == 0 && !done_b && busy_b, "R11", "reset B", {sync_b, prst_b, done_b}, 0);

    // R1: partial lock never starts anything
    lock_a = 3'b011;
    lock_b = 2'b01;
    repeat (80) @(negedge clk);
    check(sync_a == 0 && prst_a == 0, "R1", "partial lock A", int'(sync_a), 0);
    check(sync_b == 0 && prst_b == 0, "R1", "partial lock B", int'(sync_b), 0);

    // R2 R3 R4 R5 R6 R7: full bring-up timed from the last lane
    lock_a = 3'b111;
    lock_b = 2'b11;
    push_a(cyc);
    push_b(cyc);
    drain();

    // R8: done holds, lock loss ignored after done
    lock_a = 3'b101;
    lock_b = 2'b10;
    repeat (10) @(negedge clk);
    check(done_a && !busy_a && sync_a == 0 && prst_a == 0, "R8", "lock loss in done A", int'(done_a), 1);
    check(done_b && !busy_b && sync_b == 0 && prst_b == 0, "R8", "lock loss in done B", int'(done_b), 1);
    lock_a = 3'b111;
    lock_b = 2'b11;
    repeat (5) @(negedge clk);

    // R10: restart both instances
    restart_a = 1'b1;
    restart_b = 1'b1;
    t = cyc;
    exp_a.push_back('{t + 1, 5'b00000, "R10"});
    exp_b.push_back('{t + 1, 5'b00000, "R10"});
    push_a(t);
    push_b(t);
    @(negedge clk);
    restart_a = 1'b0;
    restart_b = 1'b0;
    drain();

    // R9: lock loss during the sync window, then requalification
    restart_a = 1'b1;
    t = cyc;
    s = sync_start(t, 1'b0, HOLD_A);
    exp_a.push_back('{t + 1, 5'b00000, "R10"});
    exp_a.push_back('{s, 5'b11000, "R2"});
    @(negedge clk);
    restart_a = 1'b0;
    while (cyc < s + 10) @(negedge clk);
    lock_a = 3'b011;
    exp_a.push_back('{cyc + 3, 5'b00000, "R9"});
    repeat (5) @(negedge clk);
    lock_a = 3'b111;
    push_a(cyc);
    drain();

    check(exp_a.size() == 0, "R9", "queue A empty", exp_a.size(), 0);
    check(exp_b.size() == 0, "R5", "queue B empty", exp_b.size(), 0);
    check(done_a && done_b, "R8", "final done", int'({done_a, done_b}), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule